// File: doc/BRIEF.md
# Per-PC Miss Tempo Classifier

This block sorts the program counters of a memory-access stream by how quickly each one produces cache misses. It holds a small table of rows. A fold hash of the PC selects a row. Each row keeps a short shift register of recent miss-count deltas and one stored miss-count timestamp. An update pushes a new delta into the head of the selected row, and the oldest entry falls off the tail.

A query also hashes a PC and reads its row. It averages the row's history with integer truncation and turns the average into a two-bit tempo class: short, mid, long or very long. A downstream prefetcher uses this class to choose a pattern table.

A separate stamp port returns the gap between a supplied miss-count timestamp and the one stored in the row, and can replace the stored value with the new one. The timestamp counts misses, not clock cycles. A design normally uses two instances. A local one is three entries deep and is updated at access time. A global one is seven entries deep and is updated at fill time.

Top module: `tempo_classifier`

## Requirements
- R1: Reset clears every history entry and every stored timestamp to zero. After reset, any query returns a mean of 0 and class 0, and a stamp gap equals the supplied timestamp.
- R2: The row index is the XOR of PC bits [4:0], [9:5], [14:10] and [19:15]. PC bits above 19 do not affect the index, and PCs that fold to the same index share one row.
- R3: An update with `upd_valid` high writes `upd_delta` into position 0 of the row, moves each older entry one position toward the tail, and drops the entry in the last position.
- R4: `qry_mean` is the sum of the queried row's HIST_W entries divided by HIST_W, with the remainder discarded.
- R5: `qry_class` is 0 for a mean of 4 or less, 1 for a mean of 5 to 9, 2 for a mean of 10 to 15, and 3 for a mean of 16 or more.
- R6: When an update and a query address the same row in the same cycle, the query reports the history as it was before that update. The update shows on the next cycle.
- R7: `stamp_gap` is `stamp_now` minus the row's stored timestamp, modulo 2^STAMP_W. A clock edge with `stamp_valid` high replaces the stored value with `stamp_now`. With `stamp_valid` low, the stored value is kept.
- R8: An update changes only the addressed row. A query of any other row returns the same mean as before.
- R9: While `upd_valid` is low, no history changes, whatever values `upd_pc` and `upd_delta` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Push a delta into the addressed row this cycle |
| upd_pc | input | PC_W | PC that selects the row to update |
| upd_delta | input | DELTA_W | Miss-count delta to insert at the head |
| qry_pc | input | PC_W | PC that selects the row to classify |
| qry_mean | output | DELTA_W | Truncated mean of the queried row |
| qry_class | output | 2 | Tempo class: 0 short, 1 mid, 2 long, 3 very long |
| stamp_valid | input | 1 | Store `stamp_now` in the addressed row at the clock edge |
| stamp_pc | input | PC_W | PC that selects the timestamp row |
| stamp_now | input | STAMP_W | Current miss-count timestamp |
| stamp_gap | output | STAMP_W | Supplied timestamp minus the stored timestamp |

## Verification
The hardest case to create from the ports is a collision between two different PCs on one row. The hash hides which PCs meet, so the stimulus builds PCs whose 5-bit slices XOR to the same index. One places the value in bits [9:5], one in bits [19:15], and one sets bits above 19. The test then checks that the history built under one PC shows up under the others.

The same-cycle read-before-write case is driven on purpose. The bench holds the update and the query on one row across a single edge and samples the query both before and after that edge. A table of deltas walks the mean across every class boundary (4/5, 9/10, 15/16) and also fills the history with maximum deltas.

// File: rtl/tempo_pkg.sv
package tempo_pkg;

    typedef enum logic [1:0] {
        TEMPO_SHORT = 2'd0,
        TEMPO_MID   = 2'd1,
        TEMPO_LONG  = 2'd2,
        TEMPO_VLONG = 2'd3
    } tempo_e;

    // Upper bounds (inclusive) of the first three classes.
    localparam logic [31:0] LIM_SHORT = 32'd4;
    localparam logic [31:0] LIM_MID   = 32'd9;
    localparam logic [31:0] LIM_LONG  = 32'd15;

    function automatic tempo_e tempo_bin(input logic [31:0] avg);
        if (avg <= LIM_SHORT)     return TEMPO_SHORT;
        else if (avg <= LIM_MID)  return TEMPO_MID;
        else if (avg <= LIM_LONG) return TEMPO_LONG;
        else                      return TEMPO_VLONG;
    endfunction

endpackage

// File: rtl/tempo_pc_fold.sv
module tempo_pc_fold #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 5,
    parameter int FOLDS = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int USED_W = IDX_W * FOLDS;

    initial begin
        if (USED_W > PC_W) $error("tempo_pc_fold: PC too narrow for fold count");
    end

    logic [IDX_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int f = 0; f < FOLDS; f++) begin
            acc = acc ^ pc[f*IDX_W +: IDX_W];
        end
    end

    assign idx = acc;
endmodule

// File: rtl/tempo_history_bank.sv
module tempo_history_bank #(
    parameter int ROWS    = 32,
    parameter int HIST_W  = 3,
    parameter int DELTA_W = 8,
    localparam int IDX_W  = $clog2(ROWS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [DELTA_W-1:0]              wr_delta,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [HIST_W-1:0][DELTA_W-1:0]  rd_hist
);
    logic [HIST_W-1:0][DELTA_W-1:0] hist_q [ROWS];
    logic [ROWS-1:0]                row_hit;

    for (genvar r = 0; r < ROWS; r++) begin : g_hit
        assign row_hit[r] = wr_en && (wr_idx == IDX_W'(r));
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (rst) begin
                hist_q[r] <= '0;
            end else if (row_hit[r]) begin
                hist_q[r][0] <= wr_delta;
                for (int p = 1; p < HIST_W; p++) begin
                    hist_q[r][p] <= hist_q[r][p-1];
                end
            end
        end
    end

    // Read returns the stored (pre-update) history.
    assign rd_hist = hist_q[rd_idx];

    // R3: new delta lands at the head of the addressed row
    p_head_write_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_delta));

    if (HIST_W > 1) begin : g_shift_chk
        // R3: previous head moves one step toward the tail
        p_shift_step_r3: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> hist_q[$past(wr_idx)][1] == $past(hist_q[wr_idx][0]));
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
        // R8, R9: a row not addressed by a valid update keeps its contents
        p_row_keep_r8: assert property (@(posedge clk) disable iff (rst)
            !row_hit[r] |=> $stable(hist_q[r]));
    end
endmodule

// File: rtl/tempo_stamp_bank.sv
module tempo_stamp_bank #(
    parameter int ROWS    = 32,
    parameter int STAMP_W = 16,
    localparam int IDX_W  = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [STAMP_W-1:0] now,
    output logic [STAMP_W-1:0] gap
);
    logic [STAMP_W-1:0] last_q [ROWS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (rst)                          last_q[r] <= '0;
            else if (en && idx == IDX_W'(r))  last_q[r] <= now;
        end
    end

    assign gap = now - last_q[idx];

    // R7: the stored timestamp is replaced by the supplied one
    p_stamp_store_r7: assert property (@(posedge clk) disable iff (rst)
        en |=> last_q[$past(idx)] == $past(now));

    // R7: without a store the addressed value is kept
    p_stamp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> last_q[$past(idx)] == $past(last_q[idx]));
endmodule

// File: rtl/tempo_summary.sv
module tempo_summary
    import tempo_pkg::*;
#(
    parameter int HIST_W  = 3,
    parameter int DELTA_W = 8
) (
    input  logic [HIST_W-1:0][DELTA_W-1:0] hist,
    output logic [DELTA_W-1:0]             mean,
    output tempo_e                         cls
);
    localparam int SUM_W = DELTA_W + $clog2(HIST_W) + 1;
    localparam bit POW2  = (HIST_W & (HIST_W - 1)) == 0;

    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] quot;

    always_comb begin
        total = '0;
        for (int i = 0; i < HIST_W; i++) begin
            total = total + SUM_W'(hist[i]);
        end
    end

    if (POW2) begin : g_shift_div
        assign quot = total >> $clog2(HIST_W);
    end else begin : g_const_div
        assign quot = total / SUM_W'(HIST_W);
    end

    assign mean = DELTA_W'(quot);
    assign cls  = tempo_bin(32'(quot));
endmodule

// File: rtl/tempo_classifier.sv
module tempo_classifier
    import tempo_pkg::*;
#(
    parameter int ROWS    = 32,
    parameter int HIST_W  = 3,
    parameter int DELTA_W = 8,
    parameter int STAMP_W = 16,
    parameter int PC_W    = 32,
    parameter int FOLDS   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_valid,
    input  logic [PC_W-1:0]    upd_pc,
    input  logic [DELTA_W-1:0] upd_delta,
    input  logic [PC_W-1:0]    qry_pc,
    output logic [DELTA_W-1:0] qry_mean,
    output logic [1:0]         qry_class,
    input  logic               stamp_valid,
    input  logic [PC_W-1:0]    stamp_pc,
    input  logic [STAMP_W-1:0] stamp_now,
    output logic [STAMP_W-1:0] stamp_gap
);
    localparam int IDX_W = $clog2(ROWS);

    logic [IDX_W-1:0]                upd_idx, qry_idx, stamp_idx;
    logic [HIST_W-1:0][DELTA_W-1:0]  qry_hist;
    tempo_e                          qry_bin;

    tempo_pc_fold #(.PC_W(PC_W), .IDX_W(IDX_W), .FOLDS(FOLDS)) u_fold_upd (
        .pc(upd_pc), .idx(upd_idx));
    tempo_pc_fold #(.PC_W(PC_W), .IDX_W(IDX_W), .FOLDS(FOLDS)) u_fold_qry (
        .pc(qry_pc), .idx(qry_idx));
    tempo_pc_fold #(.PC_W(PC_W), .IDX_W(IDX_W), .FOLDS(FOLDS)) u_fold_stamp (
        .pc(stamp_pc), .idx(stamp_idx));

    tempo_history_bank #(.ROWS(ROWS), .HIST_W(HIST_W), .DELTA_W(DELTA_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_delta (upd_delta),
        .rd_idx   (qry_idx),
        .rd_hist  (qry_hist)
    );

    tempo_summary #(.HIST_W(HIST_W), .DELTA_W(DELTA_W)) u_sum (
        .hist (qry_hist),
        .mean (qry_mean),
        .cls  (qry_bin)
    );

    assign qry_class = qry_bin;

    tempo_stamp_bank #(.ROWS(ROWS), .STAMP_W(STAMP_W)) u_stamp (
        .clk (clk),
        .rst (rst),
        .en  (stamp_valid),
        .idx (stamp_idx),
        .now (stamp_now),
        .gap (stamp_gap)
    );

    // R1: the first cycle after reset sees an empty history everywhere
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (qry_mean == '0 && qry_class == 2'd0));

    // R9: with no update, a steady query PC gives a steady mean
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> (!$stable(qry_pc) || $stable(qry_mean)));
endmodule

// File: tb/tempo_classifier_bench.sv
module tempo_classifier_bench;
    localparam int PC_W = 32;
    localparam int DW   = 8;
    localparam int SW   = 16;
    localparam int NVEC = 17;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic [DW-1:0]   upd_delta = '0;
    logic [PC_W-1:0] qry_pc = '0;
    logic [DW-1:0]   qry_mean;
    logic [1:0]      qry_class;
    logic            stamp_valid = 1'b0;
    logic [PC_W-1:0] stamp_pc = '0;
    logic [SW-1:0]   stamp_now = '0;
    logic [SW-1:0]   stamp_gap;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tempo_classifier u_tempo_classifier (
        .clk(clk), .rst(rst),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_delta(upd_delta),
        .qry_pc(qry_pc), .qry_mean(qry_mean), .qry_class(qry_class),
        .stamp_valid(stamp_valid), .stamp_pc(stamp_pc),
        .stamp_now(stamp_now), .stamp_gap(stamp_gap)
    );

    // {pc, delta, expected mean, expected class} for a 3-deep history
    localparam logic [55:0] VEC [NVEC] = '{
        {32'h3,  8'd6,   8'd2,   8'd0},
        {32'h3,  8'd9,   8'd5,   8'd1},
        {32'h3,  8'd12,  8'd9,   8'd1},
        {32'h3,  8'd20,  8'd13,  8'd2},
        {32'h3,  8'd16,  8'd16,  8'd3},
        {32'h3,  8'd0,   8'd12,  8'd2},
        {32'h3,  8'd0,   8'd5,   8'd1},
        {32'h3,  8'd14,  8'd4,   8'd0},
        {32'h3,  8'd1,   8'd5,   8'd1},
        {32'h3,  8'd15,  8'd10,  8'd2},
        {32'h3,  8'd17,  8'd11,  8'd2},
        {32'h3,  8'd29,  8'd20,  8'd3},
        {32'h3,  8'd255, 8'd100, 8'd3},
        {32'h3,  8'd255, 8'd179, 8'd3},
        {32'h3,  8'd255, 8'd255, 8'd3},
        {32'h20, 8'd45,  8'd15,  8'd2},
        {32'h20, 8'd3,   8'd16,  8'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic query(input logic [PC_W-1:0] pc, input string req,
                         input int exp_mean, input int exp_cls);
        qry_pc = pc;
        #1;
        check(req, 32'(qry_mean), 32'(exp_mean));
        check(req, 32'(qry_class), 32'(exp_cls));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of history and stamps
        @(negedge clk);
        query(32'h3, "R1 reset query", 0, 0);
        stamp_pc = 32'h3; stamp_now = 16'd7; #1;
        check("R1 reset stamp", 32'(stamp_gap), 32'd7);

        // R3 R4 R5: walk the table through every class boundary
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            upd_valid = 1'b1;
            upd_pc    = VEC[i][55:24];
            upd_delta = VEC[i][23:16];
            @(negedge clk);
            upd_valid = 1'b0;
            query(VEC[i][55:24], "R3/R4/R5 table", int'(VEC[i][15:8]), int'(VEC[i][1:0]));
        end

        // R2: folded aliases share the row of PC 0x3
        query(32'h60,        "R2 alias bits9_5",   255, 3);
        query(32'h18000,     "R2 alias bits19_15", 255, 3);
        query(32'h8000_0003, "R2 upper bits",      255, 3);
        // R8: untouched row stays empty
        query(32'h5,         "R8 other row",       0, 0);

        // R6: same-row update and query in one cycle
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h3; upd_delta = 8'd0;
        query(32'h3, "R6 pre-update view", 255, 3);
        @(negedge clk);
        upd_valid = 1'b0;
        query(32'h3, "R6 post-update view", 170, 3);
        query(32'h20, "R8 row kept", 16, 3);

        // R9: deltas with valid low are ignored
        upd_pc = 32'h3; upd_delta = 8'd99;
        repeat (2) @(negedge clk);
        query(32'h3, "R9 idle update", 170, 3);

        // R7: timestamp gap and replacement
        @(negedge clk);
        stamp_valid = 1'b1; stamp_pc = 32'h3; stamp_now = 16'd100; #1;
        check("R7 first gap", 32'(stamp_gap), 32'd100);
        @(negedge clk);
        stamp_now = 16'd130; #1;
        check("R7 gap", 32'(stamp_gap), 32'd30);
        @(negedge clk);
        stamp_now = 16'd10; #1;
        check("R7 wrap gap", 32'(stamp_gap), 32'd65416);
        @(negedge clk);
        stamp_pc = 32'h60; stamp_now = 16'd20; #1;
        check("R7 aliased gap", 32'(stamp_gap), 32'd10);
        @(negedge clk);
        stamp_valid = 1'b0; stamp_pc = 32'h3; stamp_now = 16'd50; #1;
        check("R7 stored", 32'(stamp_gap), 32'd30);
        @(negedge clk); #1;
        check("R7 kept without store", 32'(stamp_gap), 32'd30);

        // R1: reset in mid-run clears everything again
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        query(32'h3, "R1 mid-run reset", 0, 0);
        check("R1 mid-run stamp", 32'(stamp_gap), 32'd50);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule